// File: doc/BRIEF.md
# Manchester Line Decoder with Phase Selection

This block recovers data from a serial line that carries Manchester-coded bits and is sampled by the system clock at a fixed number of samples per bit. Every Manchester bit has a transition at its centre, and the direction of that transition is the bit value. Transitions between bits appear only when two neighbouring bits are equal. On random data the line therefore shows two sets of transitions, spaced half a bit apart. One set, the centre set, has an edge in every bit. The other set has edges only in some bits.

After reset the decoder takes the first edge it sees as a bit centre. From then on it expects an edge within one sample of each predicted centre. When a predicted centre passes with no edge, the guess was wrong. The block then moves its bit-time counter by half a bit and tries the other set. Each accepted edge realigns the counter, so a bit may be a sample shorter or longer than nominal. The locked flag rises only when two conditions hold. There must be eight accepted edges in a row on the current set. At least one bit period must also have shown no edge half a bit away from the centre, which proves that the current set is the centre set. After lock, each accepted centre edge gives one decoded bit with a one-clock strobe.

Top module: `manchester_rx`

## Requirements
- R1: A synchronous reset, active high, clears `rx_locked` and `rx_bit_vld` on the next clock edge and returns the decoder to waiting for a first edge. This holds also when the decoder is locked.
- R2: While locked, a low-to-high centre transition decodes as 1 and a high-to-low one as 0. The decoded bits leave in line order, and each leaves on `rx_bit` with `rx_bit_vld` high for one clock.
- R3: An edge up to one sample before or after the predicted centre is accepted, and the counter realigns to it. A stream whose bits last 7, 8 or 9 samples, with the centre 4 samples after the start, decodes with no bit lost.
- R4: Edges outside the acceptance window, such as the edges between bits, yield no decoded bit. Exactly one strobe is produced per bit after lock.
- R5: When a predicted centre passes with no edge, the counter shifts by half a bit to the other set. A decoder that first locked onto the between-bit edges recovers and then decodes the stream correctly.
- R6: With an alternating 1,0,1,0 preamble starting from an idle-low line, `rx_locked` is low after the seventh bit and high by the end of the eighth bit.
- R7: A preamble of equal bits (all 0s) never sets `rx_locked`, however long it lasts.
- R8: A missing centre edge while locked clears `rx_locked` on the next clock.
- R9: `rx_bit_vld` is high only when the decoder was locked on the cycle before, and it is never high on two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, eight samples per nominal bit |
| rst | input | 1 | Synchronous reset, active high |
| line_in | input | 1 | Raw serial line (resynchronised inside) |
| rx_bit | output | 1 | Last decoded bit value |
| rx_bit_vld | output | 1 | One-clock strobe when `rx_bit` is new |
| rx_locked | output | 1 | Centre set identified and being tracked |

## Verification
The assertions assume that line edges are at least several samples apart and that consecutive centre edges are 7 to 9 samples apart. Under that assumption the acceptance window and the half-bit window never overlap, and at most one edge falls in either of them. The stimulus builds every bit with a 4-sample first half and a second half of 3 to 5 samples. It never adds glitches, and it holds the line steady when it stops sending. Lengths and bit values come from a seeded random generator. Directed cases add an alternating preamble, a long run of 0s, a stopped line and a reset while locked.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

  typedef enum logic {
    ST_ACQ   = 1'b0,
    ST_TRACK = 1'b1
  } trk_state_t;

  // Position inside the acceptance window around the bit centre.
  function automatic bit in_window(int ph, int mid, int tol);
    return (ph >= mid - tol) && (ph <= mid + tol);
  endfunction

  // Position inside the half-bit-away window (wraps through zero).
  function automatic bit in_off_window(int ph, int osr, int tol);
    return (ph <= tol) || (ph >= osr - tol);
  endfunction

  // Counter value loaded after a miss. The miss is seen at mid+tol, and the
  // other set's centre lies osr/2 samples after the expected one. Loading
  // this value places that centre on position mid.
  function automatic int flip_load(int osr, int mid, int tol);
    return mid - (osr / 2) + tol + 1;
  endfunction

  // Saturating increment of the run length.
  function automatic int run_next(int run, int limit);
    return (run >= limit) ? limit : run + 1;
  endfunction

endpackage

// File: rtl/mrx_edge_det.sv
module mrx_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic edge_seen,
  output logic edge_up
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b0;
          else     sync_q[0] <= line_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[i] <= 1'b0;
          else     sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign edge_seen = sync_q[SYNC_STAGES-1] ^ prev_q;
  assign edge_up   = sync_q[SYNC_STAGES-1] & ~prev_q;

  // R4: an edge is only ever reported in one cycle for a single line change
  // edge_single_chk
  edge_single_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_seen && $stable(line_in) && $past(!rst)) |=> !edge_seen);

endmodule

// File: rtl/mrx_phase_track.sv
module mrx_phase_track
  import mrx_pkg::*;
#(
  parameter int OSR    = 8,
  parameter int TOL    = 1,
  parameter int LOCK_N = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_seen,
  input  logic edge_up,
  output logic hit,
  output logic hit_up,
  output logic miss,
  output logic locked
);
  localparam int MID = OSR / 2;
  localparam int PW  = $clog2(OSR);
  localparam int CW  = $clog2(LOCK_N + 1);
  localparam logic [PW-1:0] PH_ALIGN = PW'(MID + TOL);
  localparam logic [PW-1:0] PH_FLIP  = PW'(flip_load(OSR, MID, TOL));
  localparam logic [PW-1:0] PH_LAST  = PW'(OSR - 1);

  trk_state_t    state_q;
  logic [PW-1:0] ph_q;
  logic          hit_done_q;
  logic          off_seen_q;
  logic          resolved_q;
  logic          skip_eval_q;
  logic [CW-1:0] run_q;
  logic          locked_q;

  logic          in_win, win_end, in_off;
  logic          acq_edge, resolve_now, lock_set;
  logic [CW-1:0] run_nx;

  always_comb begin
    in_win      = in_window(int'(ph_q), MID, TOL);
    win_end     = (int'(ph_q) == MID + TOL);
    in_off      = in_off_window(int'(ph_q), OSR, TOL);
    acq_edge    = (state_q == ST_ACQ) && edge_seen;
    hit         = (state_q == ST_TRACK) && edge_seen && in_win && !hit_done_q;
    miss        = (state_q == ST_TRACK) && win_end && !hit_done_q && !hit;
    hit_up      = edge_up;
    resolve_now = hit && !skip_eval_q && !off_seen_q;
    run_nx      = CW'(run_next(int'(run_q), LOCK_N));
    lock_set    = hit && (int'(run_nx) >= LOCK_N) && (resolved_q || resolve_now);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_ACQ;
      ph_q        <= '0;
      hit_done_q  <= 1'b0;
      off_seen_q  <= 1'b0;
      resolved_q  <= 1'b0;
      skip_eval_q <= 1'b0;
      run_q       <= '0;
      locked_q    <= 1'b0;
    end else if (acq_edge) begin
      state_q     <= ST_TRACK;
      ph_q        <= PH_ALIGN;
      hit_done_q  <= 1'b1;
      off_seen_q  <= 1'b0;
      resolved_q  <= 1'b0;
      skip_eval_q <= 1'b0;
      run_q       <= CW'(1);
    end else if (miss) begin
      ph_q        <= PH_FLIP;
      hit_done_q  <= 1'b0;
      off_seen_q  <= 1'b0;
      resolved_q  <= 1'b0;
      skip_eval_q <= 1'b1;
      run_q       <= '0;
      locked_q    <= 1'b0;
    end else if (hit) begin
      ph_q        <= PH_ALIGN;
      hit_done_q  <= 1'b1;
      off_seen_q  <= 1'b0;
      skip_eval_q <= 1'b0;
      resolved_q  <= resolved_q | resolve_now;
      run_q       <= run_nx;
      if (lock_set) locked_q <= 1'b1;
    end else begin
      ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + PW'(1);
      if (win_end) hit_done_q <= 1'b0;
      if (edge_seen && in_off) off_seen_q <= 1'b1;
    end
  end

  assign locked = locked_q;

  // R8
  // locked_drop_chk
  locked_drop_chk: assert property (@(posedge clk) disable iff (rst)
    miss |=> !locked);

  // R6
  // lock_on_hit_chk
  lock_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(hit));

  // R6
  // lock_run_chk
  lock_run_chk: assert property (@(posedge clk) disable iff (rst)
    locked |-> (int'(run_q) == LOCK_N));

  // R5
  // flip_no_hit_chk
  flip_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
    miss |=> !hit);

endmodule

// File: rtl/mrx_bit_out.sv
module mrx_bit_out (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic hit_up,
  input  logic locked,
  output logic rx_bit,
  output logic rx_bit_vld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_bit     <= 1'b0;
      rx_bit_vld <= 1'b0;
    end else begin
      rx_bit_vld <= hit && locked;
      if (hit && locked) rx_bit <= hit_up;
    end
  end

  // R9
  // strobe_gap_chk
  strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
    rx_bit_vld |=> !rx_bit_vld);

  // R9
  // strobe_locked_chk
  strobe_locked_chk: assert property (@(posedge clk) disable iff (rst)
    rx_bit_vld |-> $past(locked));

endmodule

// File: rtl/manchester_rx.sv
module manchester_rx #(
  parameter int OSR         = 8,
  parameter int TOL         = 1,
  parameter int LOCK_N      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic rx_bit,
  output logic rx_bit_vld,
  output logic rx_locked
);
  logic edge_seen, edge_up;
  logic hit, hit_up, miss, locked;

  mrx_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .line_in(line_in),
    .edge_seen(edge_seen), .edge_up(edge_up)
  );

  mrx_phase_track #(.OSR(OSR), .TOL(TOL), .LOCK_N(LOCK_N)) u_track (
    .clk(clk), .rst(rst), .edge_seen(edge_seen), .edge_up(edge_up),
    .hit(hit), .hit_up(hit_up), .miss(miss), .locked(locked)
  );

  mrx_bit_out u_out (
    .clk(clk), .rst(rst), .hit(hit), .hit_up(hit_up), .locked(locked),
    .rx_bit(rx_bit), .rx_bit_vld(rx_bit_vld)
  );

  assign rx_locked = locked;

endmodule

// File: tb/manchester_rx_tb.sv
module manchester_rx_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_in = 1'b0;
  logic rx_bit, rx_bit_vld, rx_locked;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit saw_lock = 1'b0;
  bit sent_q[$];
  bit got_q[$];

  always #5 clk = ~clk;

  manchester_rx u_dut (
    .clk(clk), .rst(rst), .line_in(line_in),
    .rx_bit(rx_bit), .rx_bit_vld(rx_bit_vld), .rx_locked(rx_locked)
  );

  always @(negedge clk) begin
    if (!rst && rx_bit_vld) got_q.push_back(rx_bit);
    if (!rst && rx_locked) saw_lock = 1'b1;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Manchester bit: 4-sample first half, then the rest of len.
  task automatic send_bit(bit b, int len);
    sent_q.push_back(b);
    line_in = ~b;
    repeat (4) @(negedge clk);
    line_in = b;
    repeat (len - 4) @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    line_in = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    sent_q.delete();
    got_q.delete();
    saw_lock = 1'b0;
  endtask

  function automatic int suffix_errors();
    int errs = 0;
    if (got_q.size() > sent_q.size()) return got_q.size();
    for (int i = 0; i < got_q.size(); i++)
      if (got_q[i] != sent_q[sent_q.size() - got_q.size() + i]) errs++;
    return errs;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    int low_seen;
    seed = $urandom(32'd4242);
    idle(4);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(!rx_locked, "R1 locked after reset", rx_locked, 0);
    chk(!rx_bit_vld, "R1 strobe after reset", rx_bit_vld, 0);

    // Alternating preamble then random data at nominal length
    do_reset();
    for (int k = 0; k < 16; k++) begin
      send_bit((k % 2) == 0, 8);
      if (k == 6) chk(!rx_locked, "R6 locked before eighth bit", rx_locked, 0);
      if (k == 7) chk(rx_locked, "R6 locked after eighth bit", rx_locked, 1);
    end
    for (int k = 0; k < 40; k++) send_bit(1'($urandom), 8);
    idle(32);
    chk(suffix_errors() == 0, "R2 decoded values match sent", suffix_errors(), 0);
    // R4 and R9: one strobe per bit from bit 8 on, none for boundary edges
    chk(got_q.size() == 48, "R4 strobe count", got_q.size(), 48);
    chk(got_q.size() == 48, "R9 one strobe per bit", got_q.size(), 48);
    chk(!rx_locked, "R8 lock lost on silent line", rx_locked, 0);

    // Long run of 0s: ambiguous phase, must not lock
    do_reset();
    low_seen = 0;
    for (int k = 0; k < 24; k++) begin
      send_bit(1'b0, 8);
      if (rx_locked) low_seen++;
    end
    chk(low_seen == 0, "R7 no lock during equal-bit preamble", low_seen, 0);
    chk(got_q.size() == 0, "R7 no strobes during equal-bit preamble", got_q.size(), 0);
    // Then data with jittered lengths: phase must flip and lock
    send_bit(1'b1, 8);
    for (int k = 0; k < 48; k++) send_bit(1'($urandom), 7 + int'($urandom % 3));
    idle(32);
    chk(saw_lock, "R5 lock reached after phase flip", saw_lock, 1);
    chk(got_q.size() >= 30, "R5 enough bits decoded", got_q.size(), 30);
    chk(suffix_errors() == 0, "R3 jittered stream decodes", suffix_errors(), 0);

    // Directed: strict 7- and 9-sample bits alternating
    do_reset();
    for (int k = 0; k < 16; k++) send_bit((k % 2) == 0, 8);
    for (int k = 0; k < 20; k++) send_bit(1'($urandom), (k % 2) ? 9 : 7);
    idle(32);
    chk(got_q.size() == 28, "R3 no loss at window edges", got_q.size(), 28);
    chk(suffix_errors() == 0, "R2 values at window edges", suffix_errors(), 0);

    // Reset while locked
    do_reset();
    for (int k = 0; k < 12; k++) send_bit((k % 2) == 0, 8);
    chk(rx_locked, "R6 locked before reset", rx_locked, 1);
    rst = 1'b1;
    @(negedge clk);
    chk(!rx_locked, "R1 reset clears lock", rx_locked, 0);
    chk(!rx_bit_vld, "R1 reset clears strobe", rx_bit_vld, 0);
    rst = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule